// File: doc/BRIEF.md
# Interrupt Acceptance and Exception-Entry Sequencer

This block sits next to a simple CPU pipeline and decides, at each instruction boundary, whether a pending interrupt may be taken. It watches three kinds of request:

- a debug-port request, which always carries level 15;
- one external pin request, whose level is set through an input;
- a group of on-chip peripheral requests, each with its own level input and a fixed 12-bit event code.

A source qualifies when the block bit of the status register is clear and its level is strictly above the 4-bit mask field. Among the qualifying sources, the one with the highest level wins.

When a request is accepted, the block saves the next-instruction PC and the current status word into shadow registers. It writes the winner's event code into two event-code registers and sets three mode bits of the status word. It leaves the mask field untouched and redirects the pipeline to the vector base plus 0x600. A return strobe restores the status word from its shadow copy and redirects to the saved PC.

The pipeline also writes the status register through a plain write port, for example to clear the block bit in software. Status layout used throughout:

| Bits | Field |
|------|-------|
| [3:0] | mask |
| 8 | block |
| 9 | register bank |
| 10 | privileged mode |

All other bits are kept as written.

Top module: `irq_entry_seq`

## Requirements
- R1: A source is accepted only when status bit 8 is 0 and its level is strictly greater than status[3:0]. The debug request has level 15 and is therefore never taken with mask 15. A level equal to the mask is not taken.
- R2: Acceptance happens only in a cycle with `boundary` high. At the following edge `saved_pc` takes `pc_next` and `saved_status` takes the status word as it stood in that cycle.
- R3: On acceptance, status bits 8, 9 and 10 become 1 at the same edge, and every other status bit keeps its value.
- R4: `redir` is high for exactly the one cycle after an accepting cycle, with `redir_pc` equal to `vbr + 32'h600`, modulo 2^32.
- R5: On acceptance, both `evt_code_a` and `evt_code_b` take the winner's code. The codes are 0x5E0 for debug, `PIN_CODE` (default 0x200) for the pin, and peripheral i's 12-bit slice of `PER_CODES` (default 0x400 + 0x20*i).
- R6: Acceptance never changes the mask field status[3:0], whatever the source's level.
- R7: A request held off by a set block bit stays eligible. Once the block bit is cleared and the request is still present and qualifying, it is taken at the next boundary.
- R8: When `rte` is high, the status register takes `saved_status` and `redir` pulses the next cycle with `redir_pc` equal to `saved_pc`. An `rte` cycle accepts no interrupt even if `boundary` is high.
- R9: Among qualifying sources, the highest level wins. Ties go to debug first, then the pin, then peripherals in ascending index.
- R10: A synchronous reset sets status to 0x0000050F and clears `saved_pc`, `saved_status`, both event codes, `redir` and `redir_pc`.
- R11: When `sr_wr` is high in a cycle with neither `rte` nor an acceptance, status takes `sr_wdata` at the next edge. Otherwise the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| boundary | input | 1 | Instruction-boundary strobe |
| rte | input | 1 | Return-from-exception strobe |
| pc_next | input | 32 | PC of the next instruction |
| vbr | input | 32 | Vector base |
| sr_wr | input | 1 | Status write enable |
| sr_wdata | input | 32 | Status write data |
| dbg_req | input | 1 | Debug-port interrupt request |
| pin_req | input | 1 | External pin interrupt request |
| pin_level | input | 4 | Pin priority level |
| per_req | input | NPER | Peripheral requests |
| per_level | input | 4*NPER | Peripheral levels, 4 bits each, peripheral 0 in the low bits |
| status | output | 32 | Status register |
| saved_pc | output | 32 | Saved PC |
| saved_status | output | 32 | Saved status |
| evt_code_a | output | 12 | First event-code register |
| evt_code_b | output | 12 | Second event-code register |
| redir | output | 1 | Redirect strobe |
| redir_pc | output | 32 | Redirect target |

## Verification
The properties assume that every input is a known value after reset. They also assume that `vbr` and `pc_next` are meaningful in any cycle that can accept a request, since the saved and target values are compared against the prior cycle's inputs. The bench changes inputs only on the falling edge and never leaves a level or request undriven. Its random phase keeps status writes within the low eleven bits, so both blocked and unblocked states, and every mask value, are visited.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int LVL_W    = 4;
    localparam int CODE_W   = 12;
    localparam int WORD_W   = 32;
    localparam int BLK_BIT  = 8;
    localparam int BANK_BIT = 9;
    localparam int PRIV_BIT = 10;
    localparam logic [WORD_W-1:0] SR_RESET  = 32'h0000_050F;
    localparam logic [WORD_W-1:0] ENTRY_SET =
        (32'h1 << BLK_BIT) | (32'h1 << BANK_BIT) | (32'h1 << PRIV_BIT);
    localparam logic [CODE_W-1:0] DBG_CODE  = 12'h5E0;
    localparam logic [LVL_W-1:0]  DBG_LEVEL = 4'hF;

    typedef struct packed {
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] spc;
        logic [WORD_W-1:0] ssr;
        logic [CODE_W-1:0] evt_a;
        logic [CODE_W-1:0] evt_b;
        logic              redir;
        logic [WORD_W-1:0] tgt;
    } seq_state_t;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify
    import irq_entry_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic [NSRC-1:0]       req,
    input  logic [NSRC*LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]      mask,
    input  logic                  blk,
    output logic [NSRC-1:0]       qual
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign qual[i] = req[i] && !blk && (lvl[i*LVL_W +: LVL_W] > mask);
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_entry_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic [NSRC-1:0]        qual,
    input  logic [NSRC*LVL_W-1:0]  lvl,
    input  logic [NSRC*CODE_W-1:0] codes,
    output logic                   win_valid,
    output logic [CODE_W-1:0]      win_code
);
    logic [LVL_W-1:0] best_lvl;

    always_comb begin
        win_valid = 1'b0;
        win_code  = '0;
        best_lvl  = '0;
        for (int i = 0; i < NSRC; i++) begin
            // strict compare keeps the lower index on a tie
            if (qual[i] && (!win_valid || lvl[i*LVL_W +: LVL_W] > best_lvl)) begin
                win_valid = 1'b1;
                best_lvl  = lvl[i*LVL_W +: LVL_W];
                win_code  = codes[i*CODE_W +: CODE_W];
            end
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int                     NPER       = 4,
    parameter logic [CODE_W-1:0]      PIN_CODE   = 12'h200,
    parameter logic [NPER*CODE_W-1:0] PER_CODES  = {12'h460, 12'h440, 12'h420, 12'h400},
    parameter logic [WORD_W-1:0]      VEC_OFFSET = 32'h600
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   boundary,
    input  logic                   rte,
    input  logic [WORD_W-1:0]      pc_next,
    input  logic [WORD_W-1:0]      vbr,
    input  logic                   sr_wr,
    input  logic [WORD_W-1:0]      sr_wdata,
    input  logic                   dbg_req,
    input  logic                   pin_req,
    input  logic [LVL_W-1:0]       pin_level,
    input  logic [NPER-1:0]        per_req,
    input  logic [NPER*LVL_W-1:0]  per_level,
    output logic [WORD_W-1:0]      status,
    output logic [WORD_W-1:0]      saved_pc,
    output logic [WORD_W-1:0]      saved_status,
    output logic [CODE_W-1:0]      evt_code_a,
    output logic [CODE_W-1:0]      evt_code_b,
    output logic                   redir,
    output logic [WORD_W-1:0]      redir_pc
);
    localparam int NSRC = NPER + 2;

    seq_state_t st_q, st_d;

    logic [NSRC-1:0]        src_req;
    logic [NSRC*LVL_W-1:0]  src_lvl;
    logic [NSRC*CODE_W-1:0] src_code;
    logic [NSRC-1:0]        src_qual;
    logic                   win_valid;
    logic [CODE_W-1:0]      win_code;
    logic                   take;

    // index 0 = debug, 1 = pin, 2.. = peripherals
    assign src_req  = {per_req, pin_req, dbg_req};
    assign src_lvl  = {per_level, pin_level, DBG_LEVEL};
    assign src_code = {PER_CODES, PIN_CODE, DBG_CODE};

    irq_qualify #(.NSRC(NSRC)) u_qual (
        .req  (src_req),
        .lvl  (src_lvl),
        .mask (st_q.status[LVL_W-1:0]),
        .blk  (st_q.status[BLK_BIT]),
        .qual (src_qual)
    );

    irq_pick #(.NSRC(NSRC)) u_pick (
        .qual      (src_qual),
        .lvl       (src_lvl),
        .codes     (src_code),
        .win_valid (win_valid),
        .win_code  (win_code)
    );

    assign take = boundary && !rte && win_valid;

    always_comb begin
        st_d       = st_q;
        st_d.redir = 1'b0;
        if (rte) begin
            st_d.status = st_q.ssr;
            st_d.redir  = 1'b1;
            st_d.tgt    = st_q.spc;
        end else if (take) begin
            st_d.spc    = pc_next;
            st_d.ssr    = st_q.status;
            st_d.status = st_q.status | ENTRY_SET;
            st_d.evt_a  = win_code;
            st_d.evt_b  = win_code;
            st_d.redir  = 1'b1;
            st_d.tgt    = vbr + VEC_OFFSET;
        end else if (sr_wr) begin
            st_d.status = sr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= '0;
            st_q.status <= SR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign status       = st_q.status;
    assign saved_pc     = st_q.spc;
    assign saved_status = st_q.ssr;
    assign evt_code_a   = st_q.evt_a;
    assign evt_code_b   = st_q.evt_b;
    assign redir        = st_q.redir;
    assign redir_pc     = st_q.tgt;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
    import irq_entry_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              boundary,
    input logic              rte,
    input logic              dbg_req,
    input logic              take,
    input logic [WORD_W-1:0] pc_next,
    input logic [WORD_W-1:0] vbr,
    input logic [WORD_W-1:0] status,
    input logic [WORD_W-1:0] saved_pc,
    input logic [WORD_W-1:0] saved_status,
    input logic [CODE_W-1:0] evt_code_a,
    input logic [CODE_W-1:0] evt_code_b,
    input logic              redir,
    input logic [WORD_W-1:0] redir_pc
);
    p_blocked_r1: assert property (@(posedge clk) disable iff (rst)
        (boundary && !rte && status[BLK_BIT]) |=> !redir);

    p_no_take_off_boundary_r2: assert property (@(posedge clk) disable iff (rst)
        (!boundary && !rte) |=> !redir);

    p_save_r2: assert property (@(posedge clk) disable iff (rst)
        take |=> (saved_pc == $past(pc_next)) && (saved_status == $past(status)));

    p_mode_bits_r3: assert property (@(posedge clk) disable iff (rst)
        take |=> status[BLK_BIT] && status[BANK_BIT] && status[PRIV_BIT]);

    p_vector_r4: assert property (@(posedge clk) disable iff (rst)
        take |=> redir && (redir_pc == $past(vbr) + 32'h600));

    p_mask_kept_r6: assert property (@(posedge clk) disable iff (rst)
        take |=> status[LVL_W-1:0] == $past(status[LVL_W-1:0]));

    p_rte_r8: assert property (@(posedge clk) disable iff (rst)
        rte |=> redir && (status == $past(saved_status)) && (redir_pc == $past(saved_pc)));

    // R5 and R9: a qualifying debug request always wins with its fixed code
    p_dbg_first_r9: assert property (@(posedge clk) disable iff (rst)
        (boundary && !rte && dbg_req && !status[BLK_BIT] && status[3:0] != 4'hF)
        |=> (evt_code_a == 12'h5E0) && (evt_code_b == 12'h5E0));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .boundary     (boundary),
    .rte          (rte),
    .dbg_req      (dbg_req),
    .take         (take),
    .pc_next      (pc_next),
    .vbr          (vbr),
    .status       (status),
    .saved_pc     (saved_pc),
    .saved_status (saved_status),
    .evt_code_a   (evt_code_a),
    .evt_code_b   (evt_code_b),
    .redir        (redir),
    .redir_pc     (redir_pc)
);

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
    localparam int NPER = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        boundary, rte, sr_wr, dbg_req, pin_req;
    logic [31:0] pc_next, vbr, sr_wdata;
    logic [3:0]  pin_level;
    logic [NPER-1:0]   per_req;
    logic [NPER*4-1:0] per_level;
    logic [31:0] status, saved_pc, saved_status, redir_pc;
    logic [11:0] evt_code_a, evt_code_b;
    logic        redir;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_entry_seq #(.NPER(NPER)) dut (
        .clk(clk), .rst(rst), .boundary(boundary), .rte(rte),
        .pc_next(pc_next), .vbr(vbr), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .dbg_req(dbg_req), .pin_req(pin_req), .pin_level(pin_level),
        .per_req(per_req), .per_level(per_level),
        .status(status), .saved_pc(saved_pc), .saved_status(saved_status),
        .evt_code_a(evt_code_a), .evt_code_b(evt_code_b),
        .redir(redir), .redir_pc(redir_pc)
    );

    function automatic logic [11:0] per_code(int p);
        return 12'h400 + 12'(p * 32);
    endfunction

    // reference model, advanced on each rising edge
    logic [31:0] m_sr, m_spc, m_ssr, m_tgt;
    logic [11:0] m_evt;
    logic        m_redir;

    always @(posedge clk) begin
        bit found;
        logic [11:0] code;
        if (rst) begin
            m_sr = 32'h50F; m_spc = 0; m_ssr = 0; m_evt = 0; m_redir = 0; m_tgt = 0;
        end else begin
            m_redir = 0;
            if (rte) begin
                m_sr = m_ssr; m_redir = 1; m_tgt = m_spc;
            end else begin
                found = 0; code = 0;
                if (boundary && !m_sr[8]) begin
                    for (int lv = 15; lv >= 1; lv--) begin
                        if (!found && lv > m_sr[3:0]) begin
                            if (dbg_req && lv == 15) begin found = 1; code = 12'h5E0; end
                            else if (pin_req && pin_level == lv) begin found = 1; code = 12'h200; end
                            else for (int p = 0; p < NPER; p++)
                                if (!found && per_req[p] && per_level[p*4 +: 4] == lv) begin
                                    found = 1; code = per_code(p);
                                end
                        end
                    end
                end
                if (found) begin
                    m_spc = pc_next; m_ssr = m_sr; m_sr = m_sr | 32'h700;
                    m_evt = code; m_redir = 1; m_tgt = vbr + 32'h600;
                end else if (sr_wr) begin
                    m_sr = sr_wdata;
                end
            end
        end
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic compare_all();
        check("R3/R6/R11 status", status, m_sr);
        check("R2 saved_pc", saved_pc, m_spc);
        check("R2 saved_status", saved_status, m_ssr);
        check("R5 evt_a", {20'b0, evt_code_a}, {20'b0, m_evt});
        check("R5 evt_b", {20'b0, evt_code_b}, {20'b0, m_evt});
        check("R4/R8 redir", {31'b0, redir}, {31'b0, m_redir});
        check("R4/R8 redir_pc", redir_pc, m_tgt);
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
        boundary = 0; rte = 0; sr_wr = 0;
    endtask

    task automatic quiet();
        dbg_req = 0; pin_req = 0; per_req = 0;
    endtask

    initial begin
        rst = 1; boundary = 0; rte = 0; sr_wr = 0; sr_wdata = 0;
        dbg_req = 0; pin_req = 0; pin_level = 0; per_req = 0; per_level = 0;
        pc_next = 32'h1000; vbr = 32'h8000_0000;
        repeat (2) @(negedge clk);
        // R10 reset state
        check("R10 status", status, 32'h50F);
        check("R10 saved_pc", saved_pc, 0);
        check("R10 redir", {31'b0, redir}, 0);
        rst = 0;
        tick();

        // R1: block bit set at reset holds off the pin
        pin_req = 1; pin_level = 5; boundary = 1; tick();
        check("R1 blocked", {31'b0, redir}, 0);

        // R11: software clears block bit, mask 3
        sr_wr = 1; sr_wdata = 32'h403; tick();
        check("R11 write", status, 32'h403);

        // R7: still pending pin now taken
        boundary = 1; pc_next = 32'h2224; tick();
        check("R7 taken", {31'b0, redir}, 1);
        check("R5 pin code", {20'b0, evt_code_a}, 32'h200);
        check("R4 target", redir_pc, 32'h8000_0600);
        check("R6 mask", {28'b0, status[3:0]}, 3);
        check("R3 mode bits", {29'b0, status[10:8]}, 7);
        check("R2 spc", saved_pc, 32'h2224);
        quiet();

        // R8 return
        rte = 1; tick();
        check("R8 status", status, 32'h403);
        check("R8 target", redir_pc, 32'h2224);

        // R1 strict compare: pin level equal to mask 5 not taken, periph 1 at 6 taken
        sr_wr = 1; sr_wdata = 32'h005; tick();
        pin_req = 1; pin_level = 5; boundary = 1; tick();
        check("R1 equal level", {31'b0, redir}, 0);
        per_req = 4'b0010; per_level = 16'h0060; boundary = 1; tick();
        check("R9 periph code", {20'b0, evt_code_b}, {20'b0, per_code(1)});
        quiet();

        // R9 tie: pin vs periph 0 at level 7, pin wins
        sr_wr = 1; sr_wdata = 32'h002; tick();
        pin_req = 1; pin_level = 7; per_req = 4'b0001; per_level = 16'h0007;
        boundary = 1; tick();
        check("R9 tie pin", {20'b0, evt_code_a}, 32'h200);
        // R9 debug beats all
        sr_wr = 1; sr_wdata = 32'h002; tick();
        dbg_req = 1; per_req = 4'b1111; per_level = 16'hFFFF; boundary = 1; tick();
        check("R9 debug first", {20'b0, evt_code_a}, 32'h5E0);
        quiet();

        // R1 debug with mask 15 not taken
        sr_wr = 1; sr_wdata = 32'h00F; tick();
        dbg_req = 1; boundary = 1; tick();
        check("R1 dbg mask15", {31'b0, redir}, 0);
        quiet();

        // R8: rte with boundary and request, rte wins
        sr_wr = 1; sr_wdata = 32'h000; tick();
        pin_req = 1; pin_level = 9; rte = 1; boundary = 1; tick();
        check("R8 rte wins", redir_pc, m_tgt);
        quiet();

        // R2: no boundary, no acceptance
        sr_wr = 1; sr_wdata = 32'h000; tick();
        pin_req = 1; pin_level = 9; tick();
        check("R2 no boundary", {31'b0, redir}, 0);
        quiet();

        // random phase
        for (int n = 0; n < 2000; n++) begin
            boundary  = $urandom_range(0, 1);
            rte       = ($urandom_range(0, 7) == 0);
            sr_wr     = ($urandom_range(0, 3) == 0);
            sr_wdata  = 32'($urandom_range(0, 2047));
            dbg_req   = ($urandom_range(0, 15) == 0);
            pin_req   = $urandom_range(0, 1);
            pin_level = 4'($urandom_range(0, 15));
            per_req   = 4'($urandom_range(0, 15));
            per_level = 16'($urandom);
            pc_next   = $urandom;
            vbr       = $urandom;
            @(negedge clk);
            compare_all();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule